// File: doc/BRIEF.md
# CAS-before-RAS Refresh Sequencer

This block keeps a page-mode DRAM array alive by running CAS-before-RAS refresh cycles at a fixed average rate. An interval timer produces one refresh obligation per interval. Obligations collect in a small pending counter. While any obligation is pending and the sequencer is idle, the block raises a request to the access controller. When the controller grants, the block takes the strobe bus and performs one refresh cycle. It drives every RAS and every CAS lane together, so all byte lanes on both module sides refresh at once. It then frees the bus with a one-cycle done pulse.

One refresh cycle runs in this order:
1. A leading precharge with all strobes high.
2. CAS falls on every lane.
3. RAS falls.
4. CAS rises once its hold time after the RAS fall has passed.
5. RAS rises once its minimum low time has passed.
6. A trailing precharge.

The write enable stays high throughout, and the block has no data-bus drive at all. The refresh row comes from the DRAM's internal counter, so no address is produced. Every timing minimum is a nanosecond parameter. Each is rounded up to whole clock cycles from the clock-period parameter. With the defaults (8 ns clock, 15625 ns interval) the phases last:

| Phase | Cycles |
|---|---|
| Precharge | 5 |
| CAS lead | 1 |
| CAS hold after RAS fall | 2 |
| RAS low | 8 |

Back-pressure rule: the request is a level. It stays high for as many cycles as the controller withholds the grant. A grant seen while the request is high is accepted on that clock edge, and the request drops in the next cycle. A grant seen while the request is low has no effect.

Top module: `cbr_refresh_seq`

## Requirements
- R1: After reset, no request is raised until the interval timer expires. The request rises exactly INTERVAL cycles after reset release (cycle count = ceil(INTERVAL_NS / CLK_PERIOD_NS)), and a new obligation is added every INTERVAL cycles after that.
- R2: The request stays high with no grant for any number of cycles. It drops in the cycle after the edge that accepts a grant.
- R3: After the accepting edge, all strobes stay high for the leading precharge: PRE cycles, where PRE = max(ceil(precharge ns), ceil(CAS-high-to-RAS ns)). Then CAS falls, and RAS falls exactly ceil(CAS-lead ns) cycles after CAS.
- R4: After RAS falls, CAS stays low for exactly ceil(CAS-hold ns) cycles and then rises while RAS is still low.
- R5: RAS stays low for exactly ceil(RAS-low ns) cycles when that exceeds the CAS hold.
- R6: After RAS rises, all strobes stay high for ceil(precharge ns) cycles. The done output then pulses for exactly one cycle, and the sequencer returns to idle.
- R7: The write enable (active low) is high in every cycle, including reset and refresh.
- R8: All RAS lanes carry the same value in every cycle, and so do all CAS lanes. The strobes are active low, and all lanes are high in reset and idle.
- R9: Up to PEND_MAX obligations are held. If obligations remain after a refresh, the request is high again in the cycle after the done pulse.
- R10: An obligation that arrives while PEND_MAX are already pending sets the overflow flag and is dropped. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_PERIOD_NS |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Grant from the access controller, accepted while ref_req is high |
| ref_req | output | 1 | Refresh request, a level held until granted |
| ras_n | output | LANES | Row strobes, active low, all lanes identical |
| cas_n | output | LANES | Column strobes, active low, all lanes identical |
| we_n | output | 1 | Write enable, active low, always high |
| ref_done | output | 1 | One-cycle pulse ending a refresh; the bus is free again |
| ovf_err | output | 1 | Sticky flag: the refresh budget was exceeded |

## Verification
The bound checker watches the strobe ordering on every cycle:
- CAS is low at each RAS fall, and it has been low for the exact lead count.
- Each CAS rise and RAS rise lands on its exact low-time count.
- The done pulse comes only after the full trailing precharge.
- The request drops after an accepted grant.
- The overflow flag never clears.

Only the bench scenarios can show the things that depend on history across many intervals:
- the exact cycle of the first request after reset;
- the leading precharge measured from the grant;
- obligations piling up under a withheld grant and then draining;
- the point at which an extra obligation overflows.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_CSR,
    ST_CHR,
    ST_HOLD,
    ST_TRAIL,
    ST_DONE
  } cbr_state_e;

  // Round a nanosecond minimum up to whole clock cycles, never less than one.
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cbr_interval_timer.sv
module cbr_interval_timer #(
  parameter int unsigned INT_CYC = 1954
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (INT_CYC > 1) ? $clog2(INT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(INT_CYC - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cbr_pend_ctr.sv
module cbr_pend_ctr #(
  parameter int unsigned PEND_MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic take,
  output logic have,
  output logic ovf
);
  localparam int unsigned PW = $clog2(PEND_MAX + 1);
  localparam logic [PW-1:0] FULL = PW'(PEND_MAX);

  logic [PW-1:0] cnt;

  assign have = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (tick && !take) begin
        if (cnt == FULL) ovf <= 1'b1;
        else             cnt <= cnt + 1'b1;
      end else if (take && !tick) begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/cbr_strobe_fsm.sv
module cbr_strobe_fsm
  import cbr_pkg::*;
#(
  parameter int unsigned LEAD_CYC = 5,
  parameter int unsigned CSR_CYC  = 1,
  parameter int unsigned CHR_CYC  = 2,
  parameter int unsigned HOLD_CYC = 6,
  parameter int unsigned RP_CYC   = 5,
  parameter int unsigned PH_W     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic have,
  input  logic gnt,
  output logic req,
  output logic take,
  output logic ras_lo,
  output logic cas_lo,
  output logic done
);
  cbr_state_e state, state_nx;
  logic [PH_W-1:0] cnt, cnt_nx;

  assign req    = (state == ST_IDLE) && have;
  assign take   = req && gnt;
  assign cas_lo = (state == ST_CSR) || (state == ST_CHR);
  assign ras_lo = (state == ST_CHR) || (state == ST_HOLD);
  assign done   = (state == ST_DONE);

  always_comb begin
    state_nx = state;
    cnt_nx   = cnt;
    if (state == ST_IDLE) begin
      if (take) begin
        state_nx = ST_LEAD;
        cnt_nx   = PH_W'(LEAD_CYC - 1);
      end
    end else if (cnt != '0) begin
      cnt_nx = cnt - 1'b1;
    end else begin
      unique case (state)
        ST_LEAD:  begin state_nx = ST_CSR;   cnt_nx = PH_W'(CSR_CYC - 1);  end
        ST_CSR:   begin state_nx = ST_CHR;   cnt_nx = PH_W'(CHR_CYC - 1);  end
        ST_CHR:   begin state_nx = ST_HOLD;  cnt_nx = PH_W'(HOLD_CYC - 1); end
        ST_HOLD:  begin state_nx = ST_TRAIL; cnt_nx = PH_W'(RP_CYC - 1);   end
        ST_TRAIL: begin state_nx = ST_DONE;  cnt_nx = '0;                  end
        default:  begin state_nx = ST_IDLE;  cnt_nx = '0;                  end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      cnt   <= cnt_nx;
    end
  end
endmodule

// File: rtl/cbr_refresh_seq.sv
module cbr_refresh_seq
  import cbr_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned INTERVAL_NS   = 15625,
  parameter int unsigned T_CSR_NS      = 5,
  parameter int unsigned T_CHR_NS      = 10,
  parameter int unsigned T_RAS_NS      = 60,
  parameter int unsigned T_RP_NS       = 40,
  parameter int unsigned T_CRP_NS      = 5,
  parameter int unsigned PEND_MAX      = 4,
  parameter int unsigned LANES         = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic [LANES-1:0] ras_n,
  output logic [LANES-1:0] cas_n,
  output logic             we_n,
  output logic             ref_done,
  output logic             ovf_err
);
  localparam int unsigned INT_CYC  = ns2cyc(INTERVAL_NS, CLK_PERIOD_NS);
  localparam int unsigned CSR_CYC  = ns2cyc(T_CSR_NS, CLK_PERIOD_NS);
  localparam int unsigned CHR_CYC  = ns2cyc(T_CHR_NS, CLK_PERIOD_NS);
  localparam int unsigned RAS_CYC  = ns2cyc(T_RAS_NS, CLK_PERIOD_NS);
  localparam int unsigned RP_CYC   = ns2cyc(T_RP_NS, CLK_PERIOD_NS);
  localparam int unsigned CRP_CYC  = ns2cyc(T_CRP_NS, CLK_PERIOD_NS);
  localparam int unsigned LEAD_CYC = umax(RP_CYC, CRP_CYC);
  localparam int unsigned HOLD_CYC = (RAS_CYC > CHR_CYC) ? (RAS_CYC - CHR_CYC) : 1;
  localparam int unsigned RAS_EFF  = CHR_CYC + HOLD_CYC;
  localparam int unsigned MAX_PH   = umax(umax(LEAD_CYC, CSR_CYC), umax(CHR_CYC, HOLD_CYC));
  localparam int unsigned PH_W     = $clog2(MAX_PH + 1);

  logic tick, have, take, ras_lo, cas_lo;

  cbr_interval_timer #(.INT_CYC(INT_CYC)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  cbr_pend_ctr #(.PEND_MAX(PEND_MAX)) u_pend (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .take (take),
    .have (have),
    .ovf  (ovf_err)
  );

  cbr_strobe_fsm #(
    .LEAD_CYC(LEAD_CYC),
    .CSR_CYC (CSR_CYC),
    .CHR_CYC (CHR_CYC),
    .HOLD_CYC(HOLD_CYC),
    .RP_CYC  (RP_CYC),
    .PH_W    (PH_W)
  ) u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .have  (have),
    .gnt   (ref_gnt),
    .req   (ref_req),
    .take  (take),
    .ras_lo(ras_lo),
    .cas_lo(cas_lo),
    .done  (ref_done)
  );

  // Fan the single strobe pair out to every lane (R8).
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign ras_n[g] = ~ras_lo;
    assign cas_n[g] = ~cas_lo;
  end

  // Refresh never writes (R7).
  assign we_n = 1'b1;
endmodule

// File: rtl/cbr_refresh_chk.sv
module cbr_refresh_chk #(
  parameter int unsigned CSR_CYC = 1,
  parameter int unsigned CHR_CYC = 2,
  parameter int unsigned RAS_CYC = 8,
  parameter int unsigned RP_CYC  = 5,
  parameter int unsigned LANES   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_gnt,
  input logic             ref_req,
  input logic [LANES-1:0] ras_n,
  input logic [LANES-1:0] cas_n,
  input logic             ref_done,
  input logic             ovf_err
);
  logic [15:0] ras_lo_cnt, cas_lo_cnt, ras_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_lo_cnt <= '0;
      cas_lo_cnt <= '0;
      ras_hi_cnt <= '0;
    end else begin
      ras_lo_cnt <= (!ras_n[0]) ? ((ras_lo_cnt == 16'hFFFF) ? ras_lo_cnt : ras_lo_cnt + 1'b1) : '0;
      cas_lo_cnt <= (!cas_n[0]) ? ((cas_lo_cnt == 16'hFFFF) ? cas_lo_cnt : cas_lo_cnt + 1'b1) : '0;
      ras_hi_cnt <= ( ras_n[0]) ? ((ras_hi_cnt == 16'hFFFF) ? ras_hi_cnt : ras_hi_cnt + 1'b1) : '0;
    end
  end

  // R2
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_gnt) |=> !ref_req);

  // R3
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n[0]) |-> (!cas_n[0] && cas_lo_cnt == 16'(CSR_CYC)));

  // R4
  cas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n[0]) |-> (!ras_n[0] && ras_lo_cnt == 16'(CHR_CYC)));

  // R5
  ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n[0]) |-> (ras_lo_cnt == 16'(RAS_CYC)));

  // R6
  done_prech_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |-> (ras_n[0] && cas_n[0] && ras_hi_cnt >= 16'(RP_CYC)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |=> !ref_done);

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);
endmodule

bind cbr_refresh_seq cbr_refresh_chk #(
  .CSR_CYC(CSR_CYC),
  .CHR_CYC(CHR_CYC),
  .RAS_CYC(RAS_EFF),
  .RP_CYC (RP_CYC),
  .LANES  (LANES)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ref_gnt (ref_gnt),
  .ref_req (ref_req),
  .ras_n   (ras_n),
  .cas_n   (cas_n),
  .ref_done(ref_done),
  .ovf_err (ovf_err)
);

// File: tb/sim_cbr_refresh_seq.sv
module sim_cbr_refresh_seq;
  localparam int unsigned PER   = 8;
  localparam int unsigned INTNS = 800;
  localparam int unsigned PMAX  = 3;
  localparam int unsigned NS    = 24;

  function automatic int cyc(input int ns);
    return (ns + PER - 1) / PER;
  endfunction

  // Expected phase positions, counted from the first sample after the accepting edge.
  localparam int E_INT  = (INTNS + PER - 1) / PER;
  localparam int E_RP   = (40 + PER - 1) / PER;
  localparam int E_CSR  = (5 + PER - 1) / PER;
  localparam int E_CHR  = (10 + PER - 1) / PER;
  localparam int E_RAS  = (60 + PER - 1) / PER;

  // Stimulus table: grant latency in cycles after the request is seen, and
  // whether the request is expected high again right after the done pulse.
  localparam int  VEC_N = 4;
  localparam int  VEC_LAT [VEC_N] = '{0, 2, 7, 90};
  localparam bit  VEC_RQA [VEC_N] = '{1'b0, 1'b0, 1'b0, 1'b1};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_gnt = 1'b0;
  logic       ref_req, we_n, ref_done, ovf_err;
  logic [3:0] ras_n, cas_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  int cas_first, ras_first, cas_last, ras_last, done_k, done_cnt, req_after, req_k0;
  bit quiet_ok, lanes_ok;

  always #4 clk = ~clk;

  cbr_refresh_seq #(
    .CLK_PERIOD_NS(PER),
    .INTERVAL_NS  (INTNS),
    .PEND_MAX     (PMAX)
  ) u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_gnt (ref_gnt),
    .ref_req (ref_req),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .ref_done(ref_done),
    .ovf_err (ovf_err)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ref_gnt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;   // sample index 0 is this negedge
  endtask

  task automatic wait_samples(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Wait for the request, optionally hold off the grant, grant once, record the cycle.
  task automatic do_refresh(input int lat);
    bit hold_ok;
    while (!ref_req) @(negedge clk);
    hold_ok = 1;
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      if (!ref_req) hold_ok = 0;
    end
    if (lat > 0) check(hold_ok, "R2 request held without grant", hold_ok, 1);
    ref_gnt = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ref_gnt = 1'b0;
    cas_first = -1; ras_first = -1; cas_last = -1; ras_last = -1;
    done_k = -1; done_cnt = 0; req_after = -1; req_k0 = ref_req;
    quiet_ok = 1; lanes_ok = 1;
    for (int k = 0; k < NS; k++) begin
      if (k > 0) @(negedge clk);
      if (!(cas_n == 4'h0 || cas_n == 4'hF)) lanes_ok = 0;
      if (!(ras_n == 4'h0 || ras_n == 4'hF)) lanes_ok = 0;
      if (we_n !== 1'b1) quiet_ok = 0;
      if (cas_n == 4'h0) begin
        if (cas_first < 0) cas_first = k;
        cas_last = k;
      end
      if (ras_n == 4'h0) begin
        if (ras_first < 0) ras_first = k;
        ras_last = k;
      end
      if (ref_done) begin
        done_cnt++;
        if (done_k < 0) done_k = k;
      end
      if (done_k >= 0 && k == done_k + 1) req_after = ref_req;
    end
  endtask

  task automatic check_cycle(input string tag);
    check(req_k0 == 0, "R2 request drops after grant", req_k0, 0);
    check(cas_first == E_RP, "R3 leading precharge then CAS fall", cas_first, E_RP);
    check(ras_first == E_RP + E_CSR, "R3 RAS fall after CAS lead", ras_first, E_RP + E_CSR);
    check(cas_last == E_RP + E_CSR + E_CHR - 1, "R4 CAS hold after RAS fall",
          cas_last, E_RP + E_CSR + E_CHR - 1);
    check(ras_last == E_RP + E_CSR + E_RAS - 1, "R5 RAS low width",
          ras_last, E_RP + E_CSR + E_RAS - 1);
    check(done_k == E_RP + E_CSR + E_RAS + E_RP, "R6 done after trailing precharge",
          done_k, E_RP + E_CSR + E_RAS + E_RP);
    check(done_cnt == 1, "R6 single done pulse", done_cnt, 1);
    check(quiet_ok, "R7 write enable high in refresh", quiet_ok, 1);
    check(lanes_ok, "R8 lanes identical", lanes_ok, 1);
    if (tag.len() == 0) return;
  endtask

  initial begin
    #(PER * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // Reset state (R7, R8) and first request timing (R1)
    rst_n = 1'b0;
    #1;
    @(negedge clk);
    check(ras_n == 4'hF && cas_n == 4'hF, "R8 strobes high in reset", {ras_n, cas_n}, 8'hFF);
    check(we_n == 1'b1, "R7 write enable high in reset", we_n, 1);
    check(ref_req == 0 && ref_done == 0 && ovf_err == 0, "R1 quiet outputs in reset",
          {ref_req, ref_done, ovf_err}, 0);
    do_reset();
    wait_samples(E_INT - 1);
    check(ref_req == 0, "R1 no request before interval", ref_req, 0);
    wait_samples(1);
    check(ref_req == 1, "R1 request at interval", ref_req, 1);

    // Vector table walk: one refresh per entry, varied grant latency
    for (int v = 0; v < VEC_N; v++) begin
      do_refresh(VEC_LAT[v]);
      check_cycle("vec");
      check(req_after == int'(VEC_RQA[v]), "R9 request after done", req_after, VEC_RQA[v]);
    end

    // Pending fill without overflow (R9, R10)
    do_reset();
    wait_samples(3 * E_INT + 5);
    check(ovf_err == 0, "R10 no overflow at full depth", ovf_err, 0);
    do_refresh(0);
    check(req_after == 1, "R9 second pending remains", req_after, 1);
    do_refresh(0);
    check(req_after == 1, "R9 third pending remains", req_after, 1);
    do_refresh(0);
    check_cycle("drain");
    check(req_after == 0, "R9 pending drained", req_after, 0);
    check(ovf_err == 0, "R10 no overflow after drain", ovf_err, 0);

    // Overflow: one obligation beyond PEND_MAX is dropped and flagged (R10)
    do_reset();
    wait_samples(4 * E_INT - 5);
    check(ovf_err == 0, "R10 no overflow before extra obligation", ovf_err, 0);
    wait_samples(10);
    check(ovf_err == 1, "R10 overflow raised", ovf_err, 1);
    for (int i = 0; i < int'(PMAX); i++) do_refresh(0);
    check(req_after == 0, "R10 dropped obligation not refreshed", req_after, 0);
    check(ovf_err == 1, "R10 overflow sticky", ovf_err, 1);

    summary();
  end
endmodule